// File: doc/BRIEF.md
# Multi-Mode Waveform Timer

This block is a 16-bit timer/counter. A 4-bit mode input selects one of fifteen ways of counting. Each mode fixes four things: the count shape (single slope or up/down), the source of the TOP value, the moment at which the compare value moves from its input into the active copy, and the event that raises the overflow pulse. A prescaler outside the block supplies a one-cycle `tick`, and the counter advances only on cycles where `tick` is high. Compare value A and a capture/top value arrive as plain inputs, because the bus registers and the capture logic are separate blocks.

Outputs are the counter value and three registered signals. The overflow pulse and the match pulse are each one cycle wide. The waveform pin drives PWM or a square wave. Every event is judged on the count value present before the tick edge. The effect of that event appears in the cycle that follows the edge.

Top module: `wavegen_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `count` = 0, `ovf_flag` = 0, `match_flag` = 0 and `pwm_out` = 0. The internal direction resets to up and the active compare copy resets to 0.
- R2: Mode 0 counts 0 to 0xFFFF and wraps to 0. A tick taken at 0xFFFF gives `count` = 0 and `ovf_flag` = 1 in the next cycle.
- R3: TOP has three sources. Modes 1 and 5 use 0x00FF, modes 2 and 6 use 0x01FF, and modes 3 and 7 use 0x03FF. Modes 4, 9, 11 and 15 use the active compare copy. Modes 8, 10, 12 and 14 use `cap_top` directly.
- R4: `count` changes only on ticks. In the single-slope modes (0, 4, 5, 6, 7, 12, 14, 15), a tick taken at TOP loads 0, and any other tick adds 1.
- R5: The dual-slope modes (1, 2, 3, 8, 9, 10, 11) count up to TOP, step down by one on the tick taken at TOP, count down to 0, and then count up again.
- R6: The active compare copy loads `cmp_a` at a point set by the mode. Modes 0, 4 and 12 load it on every clock. Modes 1, 2, 3, 5, 6, 7, 10, 11, 14 and 15 load it only on a TOP tick. Modes 8 and 9 load it only on a tick taken at 0.
- R7: The overflow pulse source depends on the mode. Modes 0, 4 and 12 raise it on a tick taken at 0xFFFF. Fast modes (5, 6, 7, 14, 15) raise it on a TOP tick. Dual-slope modes raise it on a tick taken at 0.
- R8: `match_flag` is high for the cycle after a tick taken while `count` equals the active compare copy. This applies in every mode except 13.
- R9: In the fast modes, a TOP tick sets `pwm_out` to 1. Otherwise a match tick clears it to 0. A TOP tick wins over a match on the same tick.
- R10: In the dual-slope modes, a match tick on the up count clears `pwm_out`, and a match tick on the down count sets it.
- R11: In modes 0, 4 and 12, each match tick toggles `pwm_out`.
- R12: Mode 13 is reserved. In mode 13, `count` holds, `pwm_out` is 0 and neither pulse fires.
- R13: `ovf_flag` and `match_flag` are high only in the cycle right after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from an external prescaler |
| mode | input | 4 | Waveform mode number, 0 to 15 |
| cmp_a | input | 16 | Compare value A, double-buffered by mode |
| cap_top | input | 16 | Capture/top value, used unbuffered as TOP |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | One-cycle overflow pulse |
| match_flag | output | 1 | One-cycle compare-match pulse |
| pwm_out | output | 1 | Waveform output pin |

## Verification
The hardest condition to reach from the ports is the overflow at 0xFFFF in mode 0. No input preloads the counter, so the bench holds `tick` high for more than 65,536 consecutive cycles to walk the count all the way to the wrap.

The second hard condition is the window in which a new `cmp_a` is present but not yet active. The bench changes `cmp_a` in the middle of a period in the buffered modes. A cycle-by-cycle reference then shows whether the match moves early.

Further sweeps cover every compare value for small TOP values in one fast mode, one dual-slope mode and one clear-on-match mode. The slow-tick pattern confirms that the count holds between ticks.

// File: rtl/wgt_pkg.sv
package wgt_pkg;

  typedef enum logic [1:0] {KIND_PLAIN, KIND_FAST, KIND_DUAL, KIND_OFF} kind_e;
  typedef enum logic [1:0] {TSRC_FIXED, TSRC_CMPA, TSRC_CAPT, TSRC_NONE} tsrc_e;
  typedef enum logic [1:0] {UPD_NOW, UPD_TOP, UPD_BOTTOM, UPD_HOLD} upd_e;
  typedef enum logic [1:0] {OVF_MAX, OVF_TOP, OVF_BOTTOM, OVF_NONE} ovf_e;

  typedef struct packed {
    kind_e      kind;
    tsrc_e      tsrc;
    logic [1:0] fix_sel;  // 0: 8-bit, 1: 9-bit, 2: 10-bit, 3: full range
    upd_e       upd;
    ovf_e       ovf;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    c = '{KIND_OFF, TSRC_NONE, 2'd3, UPD_HOLD, OVF_NONE};
    case (m)
      4'd0:               c = '{KIND_PLAIN, TSRC_FIXED, 2'd3, UPD_NOW, OVF_MAX};
      4'd1, 4'd2, 4'd3:   c = '{KIND_DUAL, TSRC_FIXED, m[1:0] - 2'd1, UPD_TOP, OVF_BOTTOM};
      4'd4:               c = '{KIND_PLAIN, TSRC_CMPA, 2'd3, UPD_NOW, OVF_MAX};
      4'd5, 4'd6, 4'd7:   c = '{KIND_FAST, TSRC_FIXED, m[1:0] - 2'd1, UPD_TOP, OVF_TOP};
      4'd8:               c = '{KIND_DUAL, TSRC_CAPT, 2'd3, UPD_BOTTOM, OVF_BOTTOM};
      4'd9:               c = '{KIND_DUAL, TSRC_CMPA, 2'd3, UPD_BOTTOM, OVF_BOTTOM};
      4'd10:              c = '{KIND_DUAL, TSRC_CAPT, 2'd3, UPD_TOP, OVF_BOTTOM};
      4'd11:              c = '{KIND_DUAL, TSRC_CMPA, 2'd3, UPD_TOP, OVF_BOTTOM};
      4'd12:              c = '{KIND_PLAIN, TSRC_CAPT, 2'd3, UPD_NOW, OVF_MAX};
      4'd14:              c = '{KIND_FAST, TSRC_CAPT, 2'd3, UPD_TOP, OVF_TOP};
      4'd15:              c = '{KIND_FAST, TSRC_CMPA, 2'd3, UPD_TOP, OVF_TOP};
      default:            c = '{KIND_OFF, TSRC_NONE, 2'd3, UPD_HOLD, OVF_NONE};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/wgt_top_select.sv
module wgt_top_select #(
  parameter int CNT_W = 16
) (
  input  wgt_pkg::mode_cfg_t cfg,
  input  logic [CNT_W-1:0]   ocr,
  input  logic [CNT_W-1:0]   cap,
  output logic [CNT_W-1:0]   top
);
  import wgt_pkg::*;

  localparam logic [CNT_W-1:0] TOP_W8  = CNT_W'(255);
  localparam logic [CNT_W-1:0] TOP_W9  = CNT_W'(511);
  localparam logic [CNT_W-1:0] TOP_W10 = CNT_W'(1023);
  localparam logic [CNT_W-1:0] TOP_MAX = '1;

  logic [CNT_W-1:0] fixed_top;

  always_comb begin
    case (cfg.fix_sel)
      2'd0:    fixed_top = TOP_W8;
      2'd1:    fixed_top = TOP_W9;
      2'd2:    fixed_top = TOP_W10;
      default: fixed_top = TOP_MAX;
    endcase
  end

  always_comb begin
    case (cfg.tsrc)
      TSRC_CMPA: top = ocr;
      TSRC_CAPT: top = cap;
      default:   top = fixed_top;
    endcase
  end

endmodule

// File: rtl/wgt_counter.sv
module wgt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  wgt_pkg::kind_e   kind,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             down,
  output logic             at_top,
  output logic             at_bottom
);
  import wgt_pkg::*;

  logic dual;
  logic active;
  logic zero;
  logic hit_top;

  always_comb begin
    dual    = (kind == KIND_DUAL);
    active  = (kind != KIND_OFF);
    zero    = (cnt == '0);
    // dual slope turns at or above TOP so a lowered TOP cannot be overrun
    hit_top = dual ? (!down && (cnt >= top)) : (cnt == top);
    at_top    = tick && active && hit_top;
    at_bottom = tick && dual && zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      down <= 1'b0;
    end else begin
      if (active && !dual) begin
        down <= 1'b0;
      end
      if (tick && active) begin
        if (!dual) begin
          cnt <= hit_top ? '0 : cnt + CNT_W'(1);
        end else if (!down) begin
          if (hit_top) begin
            if (!zero) begin
              down <= 1'b1;
              cnt  <= cnt - CNT_W'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end else begin
          if (zero) begin
            down <= 1'b0;
            cnt  <= cnt + CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/wgt_cmp_buffer.sv
module wgt_cmp_buffer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  wgt_pkg::upd_e    upd,
  input  logic             at_top,
  input  logic             at_bottom,
  input  logic [CNT_W-1:0] cmp_in,
  output logic [CNT_W-1:0] ocr
);
  import wgt_pkg::*;

  logic load;

  always_comb begin
    case (upd)
      UPD_NOW:    load = 1'b1;
      UPD_TOP:    load = at_top;
      UPD_BOTTOM: load = at_bottom;
      default:    load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr <= '0;
    end else if (load) begin
      ocr <= cmp_in;
    end
  end

endmodule

// File: rtl/wgt_wave_out.sv
module wgt_wave_out (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  wgt_pkg::kind_e kind,
  input  logic           at_top,
  input  logic           match,
  input  logic           down,
  output logic           pwm
);
  import wgt_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm <= 1'b0;
    end else if (kind == KIND_OFF) begin
      pwm <= 1'b0;
    end else if (tick) begin
      case (kind)
        KIND_FAST: begin
          if (at_top)     pwm <= 1'b1;
          else if (match) pwm <= 1'b0;
        end
        KIND_DUAL: begin
          if (match) pwm <= down;
        end
        default: begin
          if (match) pwm <= ~pwm;
        end
      endcase
    end
  end

endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [3:0]       mode,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cap_top,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             match_flag,
  output logic             pwm_out
);
  import wgt_pkg::*;

  mode_cfg_t        cfg;
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] ocr;
  logic             down;
  logic             at_top;
  logic             at_bottom;
  logic             match_ev;
  logic             ovf_ev;

  always_comb cfg = decode_mode(mode);

  wgt_top_select #(.CNT_W(CNT_W)) u_top_select (
    .cfg (cfg),
    .ocr (ocr),
    .cap (cap_top),
    .top (top)
  );

  wgt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .kind      (cfg.kind),
    .top       (top),
    .cnt       (count),
    .down      (down),
    .at_top    (at_top),
    .at_bottom (at_bottom)
  );

  wgt_cmp_buffer #(.CNT_W(CNT_W)) u_cmp_buffer (
    .clk       (clk),
    .rst       (rst),
    .upd       (cfg.upd),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .cmp_in    (cmp_a),
    .ocr       (ocr)
  );

  always_comb begin
    match_ev = tick && (cfg.kind != KIND_OFF) && (count == ocr);
    case (cfg.ovf)
      OVF_MAX:    ovf_ev = tick && (count == '1);
      OVF_TOP:    ovf_ev = at_top;
      OVF_BOTTOM: ovf_ev = at_bottom;
      default:    ovf_ev = 1'b0;
    endcase
  end

  wgt_wave_out u_wave_out (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .kind   (cfg.kind),
    .at_top (at_top),
    .match  (match_ev),
    .down   (down),
    .pwm    (pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag   <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      ovf_flag   <= ovf_ev;
      match_flag <= match_ev;
    end
  end

endmodule

// File: rtl/wgt_checker.sv
module wgt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [3:0]       mode,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             match_flag,
  input logic             pwm_out
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !ovf_flag && !match_flag && !pwm_out));

  assert_wrap_at_max_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd0 && tick && count == '1) |=> (count == '0 && ovf_flag));

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  assert_turn_at_top_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd1 && tick && count == CNT_W'(255)) |=> (count == CNT_W'(254)));

  assert_rise_from_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd1 && tick && count == '0) |=> (count == CNT_W'(1)));

  assert_reserved_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd13) |=> ($stable(count) && !ovf_flag && !match_flag && !pwm_out));

  assert_ovf_after_tick_R13: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> $past(tick));

  assert_match_after_tick_R13: assert property (@(posedge clk) disable iff (rst)
    match_flag |-> $past(tick));

endmodule

bind wavegen_timer wgt_checker #(.CNT_W(CNT_W)) u_wgt_checker (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .mode       (mode),
  .count      (count),
  .ovf_flag   (ovf_flag),
  .match_flag (match_flag),
  .pwm_out    (pwm_out)
);

// File: tb/test_wavegen_timer.sv
`timescale 1ns/1ps
module test_wavegen_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [15:0] cmp_a = '0;
  logic [15:0] cap_top = '0;
  logic [15:0] count;
  logic        ovf_flag;
  logic        match_flag;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  int fail_prints = 0;

  // reference state
  logic [15:0] m_cnt;
  logic        m_dir;
  logic [15:0] m_ocr;
  logic        m_ovf;
  logic        m_match;
  logic        m_pwm;
  int          phase_max;

  always #2 clk = ~clk;

  wavegen_timer #(.CNT_W(16)) i_wavegen_timer (
    .clk (clk), .rst (rst), .tick (tick), .mode (mode),
    .cmp_a (cmp_a), .cap_top (cap_top), .count (count),
    .ovf_flag (ovf_flag), .match_flag (match_flag), .pwm_out (pwm_out)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      if (fail_prints < 40) begin
        fail_prints++;
        $display("FAIL %s mode=%0d: got %0d expected %0d at %0t", tag, mode, got, exp, $time);
      end
    end
  endtask

  // 0 plain, 1 fast, 2 dual, 3 reserved
  function automatic int kind_of(input logic [3:0] md);
    case (md)
      4'd0, 4'd4, 4'd12:                       return 0;
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15:          return 1;
      4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11: return 2;
      default:                                 return 3;
    endcase
  endfunction

  function automatic logic [15:0] top_of(input logic [3:0] md, input logic [15:0] ocr,
                                         input logic [15:0] cap);
    case (md)
      4'd1, 4'd5: return 16'h00FF;
      4'd2, 4'd6: return 16'h01FF;
      4'd3, 4'd7: return 16'h03FF;
      4'd4, 4'd9, 4'd11, 4'd15: return ocr;
      4'd8, 4'd10, 4'd12, 4'd14: return cap;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_dir = 1'b0; m_ocr = '0;
    m_ovf = 1'b0; m_match = 1'b0; m_pwm = 1'b0;
    phase_max = 0;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input logic tk);
    int k;
    logic [15:0] tp;
    logic at_t, at_b, mev, oev, hit;
    string ctag, ptag;
    tick = tk;
    k  = kind_of(mode);
    tp = top_of(mode, m_ocr, cap_top);
    hit  = (k == 2) ? (!m_dir && m_cnt >= tp) : (m_cnt == tp);
    at_t = tk && (k != 3) && hit;
    at_b = tk && (k == 2) && (m_cnt == 0);
    mev  = tk && (k != 3) && (m_cnt == m_ocr);
    case (k)
      0: oev = tk && (m_cnt == 16'hFFFF);
      1: oev = at_t;
      2: oev = at_b;
      default: oev = 1'b0;
    endcase
    m_ovf = oev;
    m_match = mev;
    // waveform pin
    if (k == 3) m_pwm = 1'b0;
    else if (tk) begin
      if (k == 1) begin
        if (at_t) m_pwm = 1'b1; else if (mev) m_pwm = 1'b0;
      end else if (k == 2) begin
        if (mev) m_pwm = m_dir;
      end else begin
        if (mev) m_pwm = ~m_pwm;
      end
    end
    // compare copy
    case (mode)
      4'd0, 4'd4, 4'd12: m_ocr = cmp_a;
      4'd8, 4'd9: if (at_b) m_ocr = cmp_a;
      4'd13: ;
      default: if (at_t) m_ocr = cmp_a;
    endcase
    // counter and direction
    if (k == 0 || k == 1) m_dir = 1'b0;
    if (tk && k != 3) begin
      if (k != 2) m_cnt = hit ? 16'h0 : m_cnt + 16'd1;
      else if (!m_dir) begin
        if (hit) begin
          if (m_cnt != 0) begin m_dir = 1'b1; m_cnt = m_cnt - 16'd1; end
        end else m_cnt = m_cnt + 16'd1;
      end else begin
        if (m_cnt == 0) begin m_dir = 1'b0; m_cnt = m_cnt + 16'd1; end
        else m_cnt = m_cnt - 16'd1;
      end
    end
    @(posedge clk); #1;
    case (k)
      0: begin ctag = (mode == 4'd0) ? "R2 count" : "R3/R4 count"; ptag = "R11 pwm"; end
      1: begin ctag = "R3/R4 count"; ptag = "R9 pwm"; end
      2: begin ctag = "R3/R5 count"; ptag = "R10 pwm"; end
      default: begin ctag = "R12 count"; ptag = "R12 pwm"; end
    endcase
    chk(ctag, int'(count), int'(m_cnt));
    chk("R7/R13 ovf_flag", int'(ovf_flag), int'(m_ovf));
    chk("R6/R8 match_flag", int'(match_flag), int'(m_match));
    chk(ptag, int'(pwm_out), int'(m_pwm));
    if (int'(count) > phase_max) phase_max = int'(count);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic run_phase(input logic [3:0] md, input logic [15:0] a, input logic [15:0] icr,
                           input int n, input int pat, input int exp_top,
                           input int chg_at, input logic [15:0] a2, input logic [3:0] md2);
    do_reset();
    mode = md; cmp_a = a; cap_top = icr;
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) begin cmp_a = a2; mode = md2; end
      step((pat == 0) ? 1'b1 : ((i % 3) != 2));
    end
    if (exp_top >= 0) chk("R3 highest count", phase_max, exp_top);
  endtask

  initial begin
    // R1: reset state with busy inputs applied
    rst = 1'b1; tick = 1'b1; mode = 4'd5; cmp_a = 16'h0003; cap_top = 16'h0010;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count", int'(count), 0);
    chk("R1 ovf_flag", int'(ovf_flag), 0);
    chk("R1 match_flag", int'(match_flag), 0);
    chk("R1 pwm_out", int'(pwm_out), 0);

    // R2: full sweep to the wrap in mode 0
    run_phase(4'd0, 16'h1234, 16'h0, 65600, 0, 65535, -1, 16'h0, 4'd0);
    // clear-on-match modes
    run_phase(4'd4, 16'd9, 16'h0, 120, 1, 9, -1, 16'h0, 4'd4);
    run_phase(4'd12, 16'd0, 16'd13, 120, 1, 13, -1, 16'h0, 4'd12);
    // fast PWM, fixed TOP; R6 mid-period compare change in mode 7
    run_phase(4'd5, 16'd100, 16'h0, 700, 0, 255, -1, 16'h0, 4'd5);
    run_phase(4'd6, 16'd300, 16'h0, 1100, 1, 511, -1, 16'h0, 4'd6);
    run_phase(4'd7, 16'd600, 16'h0, 2600, 0, 1023, 1500, 16'd200, 4'd7);
    // fast PWM, register TOP
    run_phase(4'd14, 16'd7, 16'd20, 120, 1, 20, 30, 16'd15, 4'd14);
    run_phase(4'd15, 16'd11, 16'h0, 120, 0, -1, 40, 16'd5, 4'd15);
    // dual slope, fixed TOP
    run_phase(4'd1, 16'd77, 16'h0, 700, 0, 255, -1, 16'h0, 4'd1);
    run_phase(4'd2, 16'd400, 16'h0, 1300, 1, 511, -1, 16'h0, 4'd2);
    run_phase(4'd3, 16'd900, 16'h0, 2300, 0, 1023, -1, 16'h0, 4'd3);
    // dual slope, register TOP; R6 bottom-update change in mode 8
    run_phase(4'd8, 16'd5, 16'd17, 150, 1, 17, 20, 16'd12, 4'd8);
    run_phase(4'd9, 16'd12, 16'h0, 150, 0, 12, -1, 16'h0, 4'd9);
    run_phase(4'd10, 16'd4, 16'd15, 150, 1, 15, -1, 16'h0, 4'd10);
    run_phase(4'd11, 16'd9, 16'h0, 150, 0, 9, -1, 16'h0, 4'd11);
    // R12: reserved mode from reset and after counting
    run_phase(4'd13, 16'd3, 16'h0, 60, 0, 0, -1, 16'h0, 4'd13);
    run_phase(4'd5, 16'd50, 16'h0, 200, 0, -1, 100, 16'd50, 4'd13);
    // sweeps of every compare value over small TOP values
    for (int a = 0; a <= 7; a++) run_phase(4'd14, 16'(a), 16'd7, 40, 0, 7, -1, 16'h0, 4'd14);
    for (int a = 0; a <= 6; a++) run_phase(4'd8, 16'(a), 16'd6, 40, 0, 6, -1, 16'h0, 4'd8);
    for (int a = 0; a <= 9; a++) run_phase(4'd4, 16'(a), 16'h0, 40, 1, a, -1, 16'h0, 4'd4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule